// File: doc/BRIEF.md
# Interval Timer Alarm

This block counts pulses from a chosen timebase and raises a sticky alarm when a programmed number of pulses has passed. It sits in the slow real-time-clock domain of a chip. Four timebase tick inputs arrive as single-cycle pulses on the block clock. A 2-bit select picks which one of them advances an 8-bit counter. When a selected pulse arrives while the counter equals the programmed interval, the block sets an event flag. While the interrupt enable is set, that flag drives the interrupt request.

Software programs the block through a small register port with two addresses. Address 0 is the control word and address 1 is the interval value. The enable, the timebase select and the interval are written into staging registers. They reach the counting logic only on the next pulse of the 128 Hz synchronising tick. The mode bit and the interrupt enable act at once. In repeat mode the counter restarts after each alarm. In one-shot mode the counter is parked after the first alarm until the timer is disabled. The flag stays set until software pulses the clear strobe.

Top module: `ivt_alarm`

## Requirements
- R1: After a synchronous active-low reset, both registers read back as zero, the counter is zero and `irq` is low.
- R2: Writes to the enable (ctrl bit 0), the timebase select (ctrl bits 3:2) and the interval (address 1) go to staging registers. They are applied on the clock edge where `sync_tick` is high. A write in that same cycle is applied at the following sync pulse. Ctrl bit 0 reads back the applied enable, so it shows the old value until the sync pulse.
- R3: While the applied enable is 1 and the counter is not parked, each pulse on `tick_src[sel]` advances the counter by one, where sel is the applied select. Pulses on the other tick inputs have no effect.
- R4: A selected pulse that arrives while the counter equals the applied interval is an alarm event. The flag is set at that clock edge. An alarm therefore comes every interval+1 selected pulses. An interval of 0 alarms on the first selected pulse after enable.
- R5: With the mode bit (ctrl bit 1) at 0, an alarm returns the counter to 0 and counting continues.
- R6: With the mode bit at 1, an alarm parks the counter at 0. No further alarm occurs until the applied enable has been 0 and is then set again.
- R7: The flag is cleared only by a `flag_clr` pulse. When an alarm and `flag_clr` fall in the same cycle, the flag stays set.
- R8: `irq` is high exactly when the flag is set and the interrupt enable (ctrl bit 4, applied immediately) is 1. A flag left over from earlier raises `irq` as soon as the enable is written to 1.
- R9: An applied enable of 0 forces the counter to 0 and stops counting. It leaves the flag as it is.
- R10: The control word reads as {2'b00, flag, irq_en, staged select, mode, applied enable}. Bits 7:5 are ignored on write, so the flag cannot be set or cleared through the register port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_tick | input | 1 | 128 Hz synchronising pulse that applies staged settings |
| tick_src | input | 4 | Timebase tick pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control, 1 interval |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| flag_clr | input | 1 | Software strobe that clears the event flag |
| irq | output | 1 | Pending interrupt request |

## Verification
The bench aims at the edges of the period and the staging rules, all of which are cases of R2 and R4. It checks that interval 3 alarms on the fourth selected pulse, not the third. A design that compares after the increment would be one pulse early. It checks that interval 0 alarms on the first pulse, and that a write landing on the sync pulse is not applied yet. It also covers a clear strobe that collides with an alarm (the flag must survive) and a disable that must zero a half-counted value. A design that only gates the tick there would resume mid-count and alarm early. Further cases are one-shot parking that must hold through many pulses, and an interrupt enable raised after the event, which must fire a request that waited while it was off.

// File: rtl/ivt_pkg.sv
// Package: shared constants for the interval timer alarm.
// Holds the register address codes and the control word bit positions
// used by both the register block and anything that decodes it.
package ivt_pkg;

    // Register addresses
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_IVAL = 1'b1;

    // Control word field positions
    localparam int F_EN     = 0;
    localparam int F_MODE   = 1;
    localparam int F_SEL_LO = 2;
    localparam int F_IE     = 4;
    localparam int F_FLAG   = 5;

    // Defaults for the top level
    localparam int DEF_CNT_W   = 8;
    localparam int DEF_NUM_SRC = 4;

endpackage

// File: rtl/ivt_tick_sel.sv
// Module: ivt_tick_sel
// Picks one of NUM_SRC tick pulses by an index.
// Assumes the ticks are single-cycle pulses already on the block clock.
// An index outside the source range selects nothing.
module ivt_tick_sel #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0] ticks,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);

    logic [NUM_SRC-1:0] gated;

    // One gate per source: pass its pulse only when it is the selected one
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign gated[g] = ticks[g] & (sel == SEL_W'(g));
    end

    // Merge the gated pulses; at most one can be active
    assign tick = |gated;

endmodule

// File: rtl/ivt_cfg.sv
// Module: ivt_cfg
// Register port and staging logic for the interval timer.
// Enable, select and interval are written into staging registers and
// applied on the sync pulse. Mode and interrupt enable act at once.
// Assumes DATA_W is at least 6 so that the control word fits.
module ivt_cfg
    import ivt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_tick,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              flag,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              en_act,
    output logic [SEL_W-1:0]  sel_act,
    output logic [DATA_W-1:0] ival_act,
    output logic              oneshot,
    output logic              irq_en
);

    logic              en_stg;
    logic [SEL_W-1:0]  sel_stg;
    logic [DATA_W-1:0] ival_stg;

    // Capture software writes into the staging and immediate registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_stg   <= 1'b0;
            sel_stg  <= '0;
            ival_stg <= '0;
            oneshot  <= 1'b0;
            irq_en   <= 1'b0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_CTRL) begin
                en_stg  <= reg_wdata[F_EN];
                oneshot <= reg_wdata[F_MODE];
                sel_stg <= reg_wdata[F_SEL_LO +: SEL_W];
                irq_en  <= reg_wdata[F_IE];
            end else begin
                ival_stg <= reg_wdata;
            end
        end
    end

    // Apply the staged settings on the synchronising pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_act   <= 1'b0;
            sel_act  <= '0;
            ival_act <= '0;
        end else if (sync_tick) begin
            en_act   <= en_stg;
            sel_act  <= sel_stg;
            ival_act <= ival_stg;
        end
    end

    // Build read data for the addressed register
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[F_EN]                = en_act;
            reg_rdata[F_MODE]              = oneshot;
            reg_rdata[F_SEL_LO +: SEL_W]   = sel_stg;
            reg_rdata[F_IE]                = irq_en;
            reg_rdata[F_FLAG]              = flag;
        end else begin
            reg_rdata = ival_stg;
        end
    end

endmodule

// File: rtl/ivt_counter.sv
// Module: ivt_counter
// Interval counter with repeat and one-shot modes.
// An alarm event fires on a tick that finds the count equal to the
// interval. Repeat mode restarts from zero; one-shot mode parks the
// counter until the enable drops. Assumes the interval is stable
// between sync pulses.
module ivt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             oneshot,
    input  logic             tick,
    input  logic [CNT_W-1:0] ival,
    output logic [CNT_W-1:0] cnt,
    output logic             held,
    output logic             hit
);

    // Alarm event: enabled, not parked, selected tick, count at interval
    assign hit = en & ~held & tick & (cnt == ival);

    // Advance, restart or park the counter
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            held <= 1'b0;
        end else if (hit) begin
            cnt  <= '0;
            held <= oneshot;
        end else if (tick && !held) begin
            cnt  <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ivt_flag.sv
// Module: ivt_flag
// Sticky alarm flag. Set by an event, cleared by the software strobe.
// An event in the same cycle as a clear takes priority.
module ivt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr,
    output logic flag
);

    // Hold the flag until cleared; a new event beats the clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/ivt_alarm.sv
// Module: ivt_alarm (top)
// Interval timer alarm: a selectable tick source drives an interval
// counter, and matches set a sticky flag that feeds the interrupt
// request. Assumes tick_src and sync_tick are single-cycle pulses
// on clk, and that NUM_SRC is at most 4 so the select fits its field.
module ivt_alarm
    import ivt_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int NUM_SRC = DEF_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_tick,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic               reg_we,
    input  logic               reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    input  logic               flag_clr,
    output logic               irq
);

    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic             en_act;
    logic [SEL_W-1:0] sel_act;
    logic [CNT_W-1:0] ival_act;
    logic             oneshot;
    logic             irq_en;
    logic             tick_sel;
    logic [CNT_W-1:0] cnt;
    logic             held;
    logic             hit;
    logic             flag;

    ivt_cfg #(
        .DATA_W (CNT_W),
        .SEL_W  (SEL_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_tick (sync_tick),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flag      (flag),
        .reg_rdata (reg_rdata),
        .en_act    (en_act),
        .sel_act   (sel_act),
        .ival_act  (ival_act),
        .oneshot   (oneshot),
        .irq_en    (irq_en)
    );

    ivt_tick_sel #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) u_sel (
        .ticks (tick_src),
        .sel   (sel_act),
        .tick  (tick_sel)
    );

    ivt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_act),
        .oneshot (oneshot),
        .tick    (tick_sel),
        .ival    (ival_act),
        .cnt     (cnt),
        .held    (held),
        .hit     (hit)
    );

    ivt_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (hit),
        .clr    (flag_clr),
        .flag   (flag)
    );

    // Request is pending while the flag is up and interrupts are enabled
    assign irq = flag & irq_en;

endmodule

// File: rtl/ivt_alarm_chk.sv
// Module: ivt_alarm_chk
// Protocol checks for ivt_alarm, attached by bind. It only observes.
module ivt_alarm_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_tick,
    input logic             flag_clr,
    input logic             irq,
    input logic             en_act,
    input logic [CNT_W-1:0] ival_act,
    input logic [CNT_W-1:0] cnt,
    input logic             held,
    input logic             hit,
    input logic             flag,
    input logic             irq_en,
    input logic             oneshot,
    input logic             tick_sel
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && !flag && !en_act));

    assert_staged_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_tick |=> ($stable(en_act) && $stable(ival_act)));

    assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_act && !held && !tick_sel) |=> $stable(cnt));

    assert_repeat_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !oneshot) |=> (cnt == '0 && !held));

    assert_oneshot_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && oneshot) |=> held);

    assert_parked_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> (cnt == '0));

    assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    assert_flag_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && flag_clr) |=> !flag);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_irq_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && irq_en) |-> irq);

    assert_disable_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_act |=> (cnt == '0));

endmodule

bind ivt_alarm ivt_alarm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_tick (sync_tick),
    .flag_clr  (flag_clr),
    .irq       (irq),
    .en_act    (en_act),
    .ival_act  (ival_act),
    .cnt       (cnt),
    .held      (held),
    .hit       (hit),
    .flag      (flag),
    .irq_en    (irq_en),
    .oneshot   (oneshot),
    .tick_sel  (tick_sel)
);

// File: tb/ivt_alarm_tb.sv
// Bench for ivt_alarm: directed corner cases, then seeded random
// traffic, compared every cycle against a model built from the
// requirements.
module ivt_alarm_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_tick = 1'b0;
    logic [3:0] tick_src = '0;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       flag_clr = 1'b0;
    logic       irq;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc_cnt = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    ivt_alarm u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_tick (sync_tick),
        .tick_src  (tick_src),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .flag_clr  (flag_clr),
        .irq       (irq)
    );

    // ---------------- reference model ----------------
    logic       m_en_stg, m_en, m_os, m_ie, m_flag, m_held;
    logic [1:0] m_sel_stg, m_sel;
    logic [7:0] m_iv_stg, m_iv, m_cnt;
    logic       m_t, m_ev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en_stg <= 0; m_en <= 0; m_os <= 0; m_ie <= 0; m_flag <= 0;
            m_held <= 0; m_sel_stg <= 0; m_sel <= 0; m_iv_stg <= 0;
            m_iv <= 0; m_cnt <= 0;
        end else begin
            if (reg_we) begin
                if (reg_addr == 1'b0) begin
                    m_en_stg  <= reg_wdata[0];
                    m_os      <= reg_wdata[1];
                    m_sel_stg <= reg_wdata[3:2];
                    m_ie      <= reg_wdata[4];
                end else begin
                    m_iv_stg <= reg_wdata;
                end
            end
            if (sync_tick) begin
                m_en <= m_en_stg; m_sel <= m_sel_stg; m_iv <= m_iv_stg;
            end
            m_t  = tick_src[m_sel];
            m_ev = m_en && !m_held && m_t && (m_cnt == m_iv);
            if (!m_en) begin
                m_cnt <= 0; m_held <= 0;
            end else if (m_ev) begin
                m_cnt <= 0; m_held <= m_os;
            end else if (m_t && !m_held) begin
                m_cnt <= m_cnt + 8'd1;
            end
            if (m_ev) m_flag <= 1;
            else if (flag_clr) m_flag <= 0;
        end
    end

    function automatic logic [7:0] exp_rd(input logic a);
        if (a == 1'b0) return {2'b00, m_flag, m_ie, m_sel_stg, m_os, m_en};
        return m_iv_stg;
    endfunction

    function automatic logic [7:0] ctrl(input logic en, input logic os,
                                        input logic [1:0] sel, input logic ie);
        return {3'b000, ie, sel, os, en};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison, sampled between edges
    always @(posedge clk) begin
        #5;
        if (mon_on && !done) begin
            chk(cur_req, {7'b0, irq}, {7'b0, m_flag & m_ie});
            chk(cur_req, reg_rdata, exp_rd(reg_addr));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc_cnt);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus helpers (called at a negedge) ----------------
    task automatic wr(input logic a, input logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic sync();
        sync_tick = 1;
        @(negedge clk);
        sync_tick = 0;
    endtask

    task automatic pulse(input int src, input int n);
        for (int i = 0; i < n; i++) begin
            tick_src = 4'b0001 << src;
            @(negedge clk);
            tick_src = '0;
        end
    endtask

    task automatic clear();
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        mon_on = 1;
        @(negedge clk);

        cur_req = "R1";
        rd(0, v); chk("R1", v, 8'h00);
        rd(1, v); chk("R1", v, 8'h00);
        chk("R1", {7'b0, irq}, 8'h00);

        cur_req = "R2";
        wr(1, 8'd3);
        wr(0, ctrl(1, 0, 2'd1, 1));
        rd(0, v); chk("R10", v, 8'h14);
        pulse(1, 5);
        chk("R2", {7'b0, irq}, 8'h00);
        sync();
        rd(0, v); chk("R2", v, 8'h15);

        cur_req = "R3";
        pulse(0, 10); pulse(2, 4);
        chk("R3", {7'b0, irq}, 8'h00);
        cur_req = "R4";
        pulse(1, 3);
        chk("R4", {7'b0, irq}, 8'h00);
        pulse(1, 1);
        chk("R4", {7'b0, irq}, 8'h01);

        cur_req = "R7";
        clear();
        chk("R7", {7'b0, irq}, 8'h00);
        cur_req = "R5";
        pulse(1, 4);
        chk("R5", {7'b0, irq}, 8'h01);
        clear();

        cur_req = "R7";
        pulse(1, 3);
        tick_src = 4'b0010; flag_clr = 1;
        @(negedge clk);
        tick_src = '0; flag_clr = 0;
        chk("R7", {7'b0, irq}, 8'h01);

        cur_req = "R9";
        pulse(1, 2);
        wr(0, ctrl(0, 0, 2'd1, 1));
        sync();
        chk("R9", {7'b0, irq}, 8'h01);
        clear();
        wr(0, ctrl(1, 0, 2'd1, 1));
        sync();
        pulse(1, 3);
        chk("R9", {7'b0, irq}, 8'h00);
        pulse(1, 1);
        chk("R9", {7'b0, irq}, 8'h01);

        cur_req = "R6";
        clear();
        wr(0, ctrl(1, 1, 2'd1, 1));
        pulse(1, 4);
        chk("R6", {7'b0, irq}, 8'h01);
        clear();
        pulse(1, 10);
        chk("R6", {7'b0, irq}, 8'h00);
        wr(0, ctrl(0, 1, 2'd1, 1)); sync();
        wr(0, ctrl(1, 1, 2'd1, 1)); sync();
        pulse(1, 4);
        chk("R6", {7'b0, irq}, 8'h01);
        clear();

        cur_req = "R8";
        wr(0, ctrl(0, 0, 2'd1, 0)); sync();
        wr(1, 8'd0);
        wr(0, ctrl(1, 0, 2'd1, 0)); sync();
        pulse(1, 1);
        chk("R8", {7'b0, irq}, 8'h00);
        rd(0, v); chk("R4", {7'b0, v[5]}, 8'h01);
        wr(0, ctrl(1, 0, 2'd1, 1));
        chk("R8", {7'b0, irq}, 8'h01);
        clear();

        cur_req = "R10";
        wr(0, 8'hE0 | ctrl(1, 0, 2'd1, 1));
        rd(0, v); chk("R10", v, 8'h15);

        cur_req = "R2";
        wr(1, 8'd5);
        reg_we = 1; reg_addr = 1; reg_wdata = 8'd1; sync_tick = 1;
        @(negedge clk);
        reg_we = 0; sync_tick = 0;
        pulse(1, 5);
        chk("R2", {7'b0, irq}, 8'h00);
        pulse(1, 1);
        chk("R2", {7'b0, irq}, 8'h01);
        clear();

        cur_req = "R5";
        for (int k = 0; k < 20000; k++) begin
            reg_we    = ($urandom % 8) == 0;
            reg_addr  = $urandom % 2;
            reg_wdata = (reg_addr == 1'b1) ? 8'($urandom % 12) : 8'($urandom);
            sync_tick = ($urandom % 16) == 0;
            tick_src  = 4'($urandom) & 4'($urandom);
            flag_clr  = ($urandom % 24) == 0;
            @(negedge clk);
        end
        reg_we = 0; sync_tick = 0; tick_src = '0; flag_clr = 0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule